// File: doc/BRIEF.md
# Tensor Register-File Vector ALU

This block is the post-processing engine of a neural-network accelerator. It holds an accumulator register file of wide vectors, each made of a parameterized number of 32-bit signed lanes. Every issued operation reads two entries, a destination and a source, and combines them lane by lane. The result is written back into the destination entry, so each update is in place. Max pooling is a chain of MAX operations. Batch normalization is a multiply by a scale followed by an add of a shift on the same entry. ReLU is a MAX against an immediate zero, so the block needs no separate activation unit.

Operations enter through a single issue port, one per cycle, with no stall. A LOAD operation writes a full vector, supplied on a fill input, into an entry. This is how tensors arrive from the surrounding datapath. Every accepted operation reports its destination index and the written vector on registered result outputs. A rejected operation instead raises an error pulse and leaves the register file untouched. A build parameter removes the multiplier for smaller builds.

Top module: `tensor_valu`

## Requirements
- R1: After a synchronous reset, and in every cycle that follows an idle issue cycle by two edges, res_valid and res_err are both low.
- R2: Opcode 4 (LOAD) writes iss_fill into entry iss_dst. Lane k of iss_fill is bits [32k+31:32k]. An operation sampled at one rising edge drives res_valid, res_dst and res_data (the written vector, same lane order) after the next rising edge.
- R3: Opcode 0 (ADD) writes dst+src in each lane, wrapping modulo 2^32.
- R4: Opcode 1 (MUL) writes the low 32 bits of the lane product dst*src.
- R5: Opcode 2 (SHL) treats bits [5:0] of each source lane as a signed shift amount. A positive amount shifts the destination lane left. A negative amount shifts it arithmetically right by the magnitude, so -32 yields all sign bits.
- R6: Opcode 3 (MAX) writes the signed maximum of dst and src. With an immediate of 0 this is ReLU.
- R7: When iss_use_imm is 1, the 16-bit iss_imm is sign-extended to 32 bits and replaces every source lane.
- R8: An operation issued in the cycle right after another sees that operation's write, whether the entry is read as destination or as source. A MUL then an ADD on one entry in consecutive cycles gives scale-then-shift.
- R9: Opcodes 5, 6 and 7 produce a one-cycle res_err pulse in place of res_valid and leave every entry unchanged.
- R10: With HAS_MUL = 0, opcode 1 is rejected exactly as in R9, while the other opcodes work unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue strobe, one operation per cycle |
| iss_op | input | 3 | Opcode: 0 ADD, 1 MUL, 2 SHL, 3 MAX, 4 LOAD |
| iss_dst | input | $clog2(DEPTH) | Destination entry, read and written |
| iss_src | input | $clog2(DEPTH) | Source entry |
| iss_use_imm | input | 1 | Use the immediate as the source operand |
| iss_imm | input | IMM_W | Signed immediate |
| iss_fill | input | LANES*LANE_W | Vector written by LOAD |
| res_valid | output | 1 | A write-back took place |
| res_dst | output | $clog2(DEPTH) | Entry written |
| res_data | output | LANES*LANE_W | Vector written |
| res_err | output | 1 | The operation two edges back was rejected |

## Verification
The bench targets the overflow edges of each lane operation, which a design with wrong lane widths or a wrong sign would miss. These include 0x7FFFFFFF+1 wrapping to 0x80000000, a product that spills past 32 bits, and shifts of +31 and -32 on a negative lane. The -32 shift would come out as zero under a logical shift, or unchanged if the amount were truncated. Back-to-back operations on the same entry, as destination and as source, expose missing forwarding: a design without it would return the value from before the previous write. Rejected opcodes are followed by a read-back through ADD with an immediate of zero. That read-back shows the damage if a faulty design wrote garbage or let a MUL through in the reduced build.

// File: rtl/valu_pkg.sv
package valu_pkg;
  localparam int OP_W = 3;
  localparam logic [OP_W-1:0] OP_ADD  = 3'd0;
  localparam logic [OP_W-1:0] OP_MUL  = 3'd1;
  localparam logic [OP_W-1:0] OP_SHL  = 3'd2;
  localparam logic [OP_W-1:0] OP_MAX  = 3'd3;
  localparam logic [OP_W-1:0] OP_LOAD = 3'd4;

  // Whether an opcode is carried out by a build with or without multiplier.
  function automatic logic op_supported(input logic [OP_W-1:0] op, input logic has_mul);
    case (op)
      OP_ADD, OP_SHL, OP_MAX, OP_LOAD: op_supported = 1'b1;
      OP_MUL:                          op_supported = has_mul;
      default:                         op_supported = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/valu_regfile.sv
module valu_regfile #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 512,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IDX_W-1:0] raddr_a,
  output logic [WIDTH-1:0] rdata_a,
  input  logic [IDX_W-1:0] raddr_b,
  output logic [WIDTH-1:0] rdata_b
);
  // Synchronous reads with read-before-write, so the array maps onto block RAM.
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end
endmodule

// File: rtl/valu_lane.sv
module valu_lane import valu_pkg::*; #(
  parameter int LANE_W  = 32,
  parameter bit HAS_MUL = 1'b1,
  localparam int SH_W   = $clog2(LANE_W) + 1
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [LANE_W-1:0] dst_i,
  input  logic [LANE_W-1:0] src_i,
  output logic [LANE_W-1:0] res_o
);
  logic [LANE_W-1:0] prod;
  logic signed [SH_W-1:0] amt;
  logic [SH_W-1:0] mag;
  logic [LANE_W-1:0] shl_l, shl_r;

  generate
    if (HAS_MUL) begin : g_mul
      assign prod = dst_i * src_i;
    end else begin : g_nomul
      assign prod = '0;
    end
  endgenerate

  assign amt   = $signed(src_i[SH_W-1:0]);
  assign mag   = amt[SH_W-1] ? SH_W'(-amt) : SH_W'(amt);
  assign shl_l = dst_i << mag;
  assign shl_r = LANE_W'($signed(dst_i) >>> mag);

  always_comb begin
    case (op_i)
      OP_ADD:  res_o = dst_i + src_i;
      OP_MUL:  res_o = prod;
      OP_SHL:  res_o = amt[SH_W-1] ? shl_r : shl_l;
      OP_MAX:  res_o = ($signed(dst_i) > $signed(src_i)) ? dst_i : src_i;
      default: res_o = dst_i;
    endcase
  end
endmodule

// File: rtl/tensor_valu.sv
module tensor_valu import valu_pkg::*; #(
  parameter int LANES   = 16,
  parameter int DEPTH   = 32,
  parameter int LANE_W  = 32,
  parameter int IMM_W   = 16,
  parameter bit HAS_MUL = 1'b1,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int VEC_W  = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iss_valid,
  input  logic [OP_W-1:0]  iss_op,
  input  logic [IDX_W-1:0] iss_dst,
  input  logic [IDX_W-1:0] iss_src,
  input  logic             iss_use_imm,
  input  logic [IMM_W-1:0] iss_imm,
  input  logic [VEC_W-1:0] iss_fill,
  output logic             res_valid,
  output logic [IDX_W-1:0] res_dst,
  output logic [VEC_W-1:0] res_data,
  output logic             res_err
);
  // Stage 1: operation captured together with the synchronous register reads.
  logic              s1_valid, s1_ok, s1_use_imm, s1_fwd_d, s1_fwd_s;
  logic [OP_W-1:0]   s1_op;
  logic [IDX_W-1:0]  s1_dst;
  logic [LANE_W-1:0] s1_imm;
  logic [VEC_W-1:0]  s1_fill, s1_fwd_data;
  logic [VEC_W-1:0]  rd_d, rd_s, opd_d, opd_s, alu_vec;
  logic              wb_en;
  logic [VEC_W-1:0]  wb_data;

  valu_regfile #(.DEPTH(DEPTH), .WIDTH(VEC_W)) u_rf (
    .clk     (clk),
    .we      (wb_en),
    .waddr   (s1_dst),
    .wdata   (wb_data),
    .raddr_a (iss_dst),
    .rdata_a (rd_d),
    .raddr_b (iss_src),
    .rdata_b (rd_s)
  );

  assign wb_en   = s1_valid && s1_ok;
  assign wb_data = (s1_op == OP_LOAD) ? s1_fill : alu_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_ok    <= 1'b0;
      s1_fwd_d <= 1'b0;
      s1_fwd_s <= 1'b0;
    end else begin
      s1_valid <= iss_valid;
      s1_ok    <= op_supported(iss_op, HAS_MUL);
      // A write landing at this edge is not yet in the RAM read data.
      s1_fwd_d <= wb_en && (iss_dst == s1_dst);
      s1_fwd_s <= wb_en && (iss_src == s1_dst);
    end
    s1_op       <= iss_op;
    s1_dst      <= iss_dst;
    s1_use_imm  <= iss_use_imm;
    s1_imm      <= {{(LANE_W-IMM_W){iss_imm[IMM_W-1]}}, iss_imm};
    s1_fill     <= iss_fill;
    s1_fwd_data <= wb_data;
  end

  assign opd_d = s1_fwd_d ? s1_fwd_data : rd_d;
  assign opd_s = s1_use_imm ? {LANES{s1_imm}} : (s1_fwd_s ? s1_fwd_data : rd_s);

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      valu_lane #(.LANE_W(LANE_W), .HAS_MUL(HAS_MUL)) u_lane (
        .op_i  (s1_op),
        .dst_i (opd_d[g*LANE_W +: LANE_W]),
        .src_i (opd_s[g*LANE_W +: LANE_W]),
        .res_o (alu_vec[g*LANE_W +: LANE_W])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_err   <= 1'b0;
      res_dst   <= '0;
      res_data  <= '0;
    end else begin
      res_valid <= wb_en;
      res_err   <= s1_valid && !s1_ok;
      if (wb_en) begin
        res_dst  <= s1_dst;
        res_data <= wb_data;
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !iss_valid |-> ##2 (!res_valid && !res_err)); // R1

  AST_ISSUE_TO_RESULT: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && op_supported(iss_op, HAS_MUL)) |-> ##2 (res_valid && !res_err && res_dst == $past(iss_dst, 2))); // R2

  AST_REJECT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !op_supported(iss_op, HAS_MUL)) |-> ##2 (res_err && !res_valid)); // R9

  AST_NO_MUL_REDUCED: assert property (@(posedge clk) disable iff (rst)
    (!HAS_MUL && iss_valid && iss_op == OP_MUL) |-> ##2 res_err); // R10

  AST_MAX_DOMINATES: assert property (@(posedge clk) disable iff (rst)
    (wb_en && s1_op == OP_MAX) |->
      ($signed(wb_data[LANE_W-1:0]) >= $signed(opd_d[LANE_W-1:0]) &&
       $signed(wb_data[LANE_W-1:0]) >= $signed(opd_s[LANE_W-1:0]))); // R6
endmodule

// File: tb/sim_tensor_valu.sv
module sim_tensor_valu;
  localparam int CLK_PERIOD = 10;
  localparam int LN = 4;
  localparam int DP = 8;
  localparam int XW = 3;
  localparam int VW = LN * 32;
  localparam int RLN = 2;
  localparam int RDP = 4;
  localparam int RXW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          a_valid = 1'b0, a_use_imm = 1'b0;
  logic [2:0]    a_op = '0;
  logic [XW-1:0] a_dst = '0, a_src = '0;
  logic [15:0]   a_imm = '0;
  logic [VW-1:0] a_fill = '0;
  logic          r_valid, r_err;
  logic [XW-1:0] r_dst;
  logic [VW-1:0] r_data;

  tensor_valu #(.LANES(LN), .DEPTH(DP), .LANE_W(32), .IMM_W(16), .HAS_MUL(1'b1)) u0 (
    .clk(clk), .rst(rst), .iss_valid(a_valid), .iss_op(a_op), .iss_dst(a_dst),
    .iss_src(a_src), .iss_use_imm(a_use_imm), .iss_imm(a_imm), .iss_fill(a_fill),
    .res_valid(r_valid), .res_dst(r_dst), .res_data(r_data), .res_err(r_err));

  logic            b_valid = 1'b0, b_use_imm = 1'b0;
  logic [2:0]      b_op = '0;
  logic [RXW-1:0]  b_dst = '0, b_src = '0;
  logic [15:0]     b_imm = '0;
  logic [RLN*32-1:0] b_fill = '0;
  logic            q_valid, q_err;
  logic [RXW-1:0]  q_dst;
  logic [RLN*32-1:0] q_data;

  tensor_valu #(.LANES(RLN), .DEPTH(RDP), .LANE_W(32), .IMM_W(16), .HAS_MUL(1'b0)) u1 (
    .clk(clk), .rst(rst), .iss_valid(b_valid), .iss_op(b_op), .iss_dst(b_dst),
    .iss_src(b_src), .iss_use_imm(b_use_imm), .iss_imm(b_imm), .iss_fill(b_fill),
    .res_valid(q_valid), .res_dst(q_dst), .res_data(q_data), .res_err(q_err));

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] mrf [DP][LN];

  // Two-deep expectation pipeline: slot 1 is due at the current falling edge.
  bit            p_live [2];
  bit            p_v    [2];
  bit            p_e    [2];
  logic [XW-1:0] p_d    [2];
  logic [VW-1:0] p_x    [2];
  string         p_tag  [2];

  function automatic logic [31:0] ref_lane(input int op, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] p;
    logic [31:0] x;
    int amt;
    case (op)
      0: return a + b;
      1: begin p = {32'd0, a} * {32'd0, b}; return p[31:0]; end
      2: begin
        amt = b[5] ? int'(b[5:0]) - 64 : int'(b[5:0]);
        x = a;
        if (amt >= 0) for (int k = 0; k < amt; k++) x = {x[30:0], 1'b0};
        else for (int k = 0; k < -amt; k++) x = {x[31], x[31:1]};
        return x;
      end
      3: return ($signed(a) > $signed(b)) ? a : b;
      default: return a;
    endcase
  endfunction

  task automatic check_slot();
    if (p_live[1]) begin
      n_chk++;
      if (r_valid !== p_v[1] || r_err !== p_e[1] ||
          (p_v[1] && (r_dst !== p_d[1] || r_data !== p_x[1]))) begin
        n_bad++;
        $display("FAIL %s: got v=%0b e=%0b dst=%0d data=%h, expected v=%0b e=%0b dst=%0d data=%h",
                 p_tag[1], r_valid, r_err, r_dst, r_data, p_v[1], p_e[1], p_d[1], p_x[1]);
      end
    end
  endtask

  task automatic step(input bit v, input int op, input int d, input int s, input bit ui,
                      input logic [15:0] imm, input logic [VW-1:0] fill, input string tag);
    logic [VW-1:0] res;
    logic [31:0] bv;
    bit ok;
    @(negedge clk);
    check_slot();
    ok = v && (op <= 4);
    res = '0;
    if (ok) begin
      for (int l = 0; l < LN; l++) begin
        bv = ui ? {{16{imm[15]}}, imm} : mrf[s][l];
        res[l*32 +: 32] = (op == 4) ? fill[l*32 +: 32] : ref_lane(op, mrf[d][l], bv);
      end
      for (int l = 0; l < LN; l++) mrf[d][l] = res[l*32 +: 32];
    end
    p_live[1] = p_live[0]; p_v[1] = p_v[0]; p_e[1] = p_e[0];
    p_d[1] = p_d[0]; p_x[1] = p_x[0]; p_tag[1] = p_tag[0];
    p_live[0] = 1'b1; p_v[0] = ok; p_e[0] = v && !ok;
    p_d[0] = XW'(d); p_x[0] = res; p_tag[0] = tag;
    a_valid = v; a_op = 3'(op); a_dst = XW'(d); a_src = XW'(s);
    a_use_imm = ui; a_imm = imm; a_fill = fill;
  endtask

  function automatic logic [VW-1:0] vec4(input logic [31:0] l0, input logic [31:0] l1,
                                         input logic [31:0] l2, input logic [31:0] l3);
    return {l3, l2, l1, l0};
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] x;
    for (int l = 0; l < LN; l++) x[l*32 +: 32] = $urandom;
    return x;
  endfunction

  task automatic rchk(input bit ev, input bit ee, input logic [RLN*32-1:0] ex, input string tag);
    n_chk++;
    if (q_valid !== ev || q_err !== ee || (ev && q_data !== ex)) begin
      n_bad++;
      $display("FAIL %s: got v=%0b e=%0b data=%h, expected v=%0b e=%0b data=%h",
               tag, q_valid, q_err, q_data, ev, ee, ex);
    end
  endtask

  task automatic rissue(input int op, input int d, input bit ui, input logic [15:0] imm,
                        input logic [RLN*32-1:0] fill);
    @(negedge clk);
    b_valid = 1'b1; b_op = 3'(op); b_dst = RXW'(d); b_src = RXW'(d);
    b_use_imm = ui; b_imm = imm; b_fill = fill;
    @(negedge clk);
    b_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int op, d, s;
    bit v, ui;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2; i++) begin p_live[i] = 1'b0; p_tag[i] = ""; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    n_chk++;
    if (r_valid !== 1'b0 || r_err !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: got v=%0b e=%0b, expected v=0 e=0", r_valid, r_err);
    end

    // R10: reduced build rejects MUL and keeps the entry
    rissue(4, 1, 1'b0, 16'd0, {32'd7, 32'hFFFF_FFFD});
    rchk(1'b1, 1'b0, {32'd7, 32'hFFFF_FFFD}, "R10 load");
    rissue(1, 1, 1'b0, 16'd0, '0);
    rchk(1'b0, 1'b1, '0, "R10 mul rejected");
    rissue(0, 1, 1'b1, 16'd0, '0);
    rchk(1'b1, 1'b0, {32'd7, 32'hFFFF_FFFD}, "R10 entry unchanged");
    rissue(3, 1, 1'b1, 16'd0, '0);
    rchk(1'b1, 1'b0, {32'd7, 32'd0}, "R10 max still works");

    // R2: fill every entry
    for (int e = 0; e < DP; e++) step(1'b1, 4, e, 0, 1'b0, '0, rnd_vec(), "R2");
    step(1'b0, 0, 0, 0, 1'b0, '0, '0, "R1");

    // R3: add wrap
    step(1'b1, 4, 0, 0, 1'b0, '0, vec4(32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'd5, 32'h8000_0000), "R2");
    step(1'b1, 4, 1, 0, 1'b0, '0, vec4(32'd1, 32'd1, 32'hFFFF_FFFB, 32'h8000_0000), "R2");
    step(1'b0, 0, 0, 0, 1'b0, '0, '0, "R1");
    step(1'b1, 0, 0, 1, 1'b0, '0, '0, "R3");
    // R4: multiply overflow
    step(1'b1, 4, 2, 0, 1'b0, '0, vec4(32'h0001_0000, 32'hFFFF_FFFF, 32'd12345, 32'h4000_0001), "R2");
    step(1'b1, 4, 3, 0, 1'b0, '0, vec4(32'h0001_0000, 32'd3, 32'hFFFF_FFFE, 32'd4), "R2");
    step(1'b0, 0, 0, 0, 1'b0, '0, '0, "R1");
    step(1'b1, 1, 2, 3, 1'b0, '0, '0, "R4");
    // R5: shifts +31, -32, -1, +4
    step(1'b1, 4, 4, 0, 1'b0, '0, vec4(32'd1, 32'h8000_0010, 32'hF000_0000, 32'h0000_00F1), "R2");
    step(1'b1, 4, 5, 0, 1'b0, '0, vec4(32'd31, 32'h0000_0020, 32'h0000_003F, 32'd4), "R2");
    step(1'b0, 0, 0, 0, 1'b0, '0, '0, "R1");
    step(1'b1, 2, 4, 5, 1'b0, '0, '0, "R5");
    step(1'b1, 2, 6, 0, 1'b1, 16'hFFFE, '0, "R5");
    // R6, R7: ReLU with immediate zero, MAX with negative immediate
    step(1'b1, 4, 7, 0, 1'b0, '0, vec4(32'hFFFF_FF00, 32'd9, 32'h8000_0000, 32'd0), "R2");
    step(1'b0, 0, 0, 0, 1'b0, '0, '0, "R1");
    step(1'b1, 3, 7, 0, 1'b1, 16'd0, '0, "R6");
    step(1'b1, 3, 0, 0, 1'b1, 16'h8000, '0, "R7");
    step(1'b1, 0, 1, 0, 1'b1, 16'hFFFF, '0, "R7");
    // R8: back-to-back on same entry, batch norm MUL then ADD
    step(1'b1, 1, 3, 0, 1'b1, 16'd3, '0, "R8");
    step(1'b1, 0, 3, 0, 1'b1, 16'hFFF6, '0, "R8");
    step(1'b1, 0, 2, 3, 1'b0, '0, '0, "R8");
    step(1'b1, 3, 3, 2, 1'b0, '0, '0, "R8");
    step(1'b1, 4, 5, 0, 1'b0, '0, vec4(32'd10, 32'd20, 32'd30, 32'd40), "R2");
    step(1'b1, 0, 5, 5, 1'b0, '0, '0, "R8");
    // R9: illegal opcodes leave the entry alone; read back via ADD imm 0
    step(1'b1, 5, 6, 1, 1'b0, '0, '0, "R9");
    step(1'b1, 6, 6, 1, 1'b0, '0, '0, "R9");
    step(1'b1, 7, 6, 1, 1'b0, '0, '0, "R9");
    step(1'b1, 0, 6, 0, 1'b1, 16'd0, '0, "R9");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      v  = ($urandom_range(0, 7) != 0);
      op = $urandom_range(0, 9);
      op = (op == 9) ? 5 + $urandom_range(0, 2) : ((op == 8) ? 4 : op / 2);
      d  = $urandom_range(0, DP-1);
      s  = $urandom_range(0, DP-1);
      ui = ($urandom_range(0, 3) == 0);
      step(v, op, d, s, ui, 16'($urandom), rnd_vec(),
           !v ? "R1" : (op == 0 ? "R3" : op == 1 ? "R4" : op == 2 ? "R5" :
                        op == 3 ? "R6" : op == 4 ? "R2" : "R9"));
    end
    step(1'b0, 0, 0, 0, 1'b0, '0, '0, "R1");
    step(1'b0, 0, 0, 0, 1'b0, '0, '0, "R1");
    step(1'b0, 0, 0, 0, 1'b0, '0, '0, "R1");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule